// File: doc/BRIEF.md
# Configurable Window Address Decoder with Boot Remap

This block turns a 32-bit system-bus address into a slave select. It holds one configuration word per slot. Each word carries a window base, counted in 1 MB units, and a size code that sets the window length to a power of two in megabytes. For each address the block raises the select line of the matching slot, or it raises a decode-error flag when no window matches. Both results are combinational from the address and the current slot words.

One slot holds the boot ROM window and another holds the main RAM window. A single remap request moves RAM down to the ROM's old base and places ROM directly above the end of the RAM window. Both size codes stay the same. Remap takes effect once, stays in force, and only reset undoes it. A combinational read port returns any slot word by index.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset, slot 3 reads 0x92050000, slot 4 (ROM) reads 0x00080000, slot 6 (RAM) reads 0x10090000 and every other slot reads 0 (default parameters).
- R2: An address selects slot k when its bits 31:20 lie in [base, base + 2^code), where base is word bits 31:20 and code is word bits 19:16; the last address of a window hits and the first one past it does not.
- R3: slave_sel is one-hot or all zero; when windows overlap, the lowest-numbered matching slot is selected.
- R4: An address that matches no slot drives decode_err high and slave_sel to zero in the same cycle, with no clock edge needed.
- R5: A slot word equal to zero never matches, even for addresses its zero base would cover.
- R6: The rising clock edge that accepts remap_req writes the RAM slot's base with the ROM slot's old base and keeps the RAM size code.
- R7: The same edge writes the ROM slot's base with the new RAM base plus 2^(RAM code) MB and keeps the ROM size code.
- R8: Remap is sticky. Further remap requests leave both slot words unchanged, and only reset restores the reset values.
- R9: cfg_rd_data returns, combinationally, the current word of the slot named by cfg_rd_idx, including the values after a remap.
- R10: The slot-3 bridge window covers 0x92000000 through 0x93FFFFFF (32 MB).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| remap_req | input | 1 | Request to swap the ROM and RAM windows, sampled on the rising edge |
| addr | input | 32 | Address to decode |
| slave_sel | output | 32 | One-hot slot select, zero on a miss |
| decode_err | output | 1 | High when no slot window matches addr |
| cfg_rd_idx | input | 5 | Slot index for the configuration read port |
| cfg_rd_data | output | 32 | Configuration word of the indexed slot |

## Verification
The select, the error flag and the read data follow addr and cfg_rd_idx in the same cycle, so no edge is involved. Each check therefore drives its inputs at a falling edge and compares 5 ns later, before the next rising edge. A remap request is held across one rising edge, and the slot words change at that edge. Every check that depends on a remap or a reset is made at the falling edge that follows it. A second instance with overlapping windows is checked the same way to cover priority.

// File: rtl/adec_pkg.sv
package adec_pkg;
  localparam int WORD_W   = 32;
  localparam int BASE_LSB = 20;
  localparam int CODE_LSB = 16;

  function automatic logic [11:0] base_of(input logic [WORD_W-1:0] w);
    return w[31:BASE_LSB];
  endfunction

  function automatic logic [3:0] code_of(input logic [WORD_W-1:0] w);
    return w[19:CODE_LSB];
  endfunction

  // Window test in megabyte units; 17 bits so size code 15 cannot overflow
  function automatic logic win_hit(input logic [WORD_W-1:0] w, input logic [31:0] a);
    logic [16:0] off;
    if (w == '0) return 1'b0;
    if (a[31:BASE_LSB] < base_of(w)) return 1'b0;
    off = {5'b0, a[31:BASE_LSB] - base_of(w)};
    return off < (17'd1 << code_of(w));
  endfunction

  function automatic logic [WORD_W-1:0] ram_after_remap(input logic [WORD_W-1:0] rom_w,
                                                        input logic [WORD_W-1:0] ram_w);
    return {base_of(rom_w), ram_w[19:0]};
  endfunction

  function automatic logic [WORD_W-1:0] rom_after_remap(input logic [WORD_W-1:0] rom_w,
                                                        input logic [WORD_W-1:0] ram_w);
    logic [11:0] nb;
    nb = base_of(rom_w) + (12'd1 << code_of(ram_w));
    return {nb, rom_w[19:0]};
  endfunction
endpackage

// File: rtl/adec_slot_bank.sv
module adec_slot_bank #(
  parameter int NSLOT    = 32,
  parameter int ROM_IDX  = 4,
  parameter int RAM_IDX  = 6,
  parameter int BRG_IDX  = 3,
  parameter logic [31:0] ROM_INIT = 32'h0008_0000,
  parameter logic [31:0] RAM_INIT = 32'h1009_0000,
  parameter logic [31:0] BRG_INIT = 32'h9205_0000,
  parameter logic [NSLOT*32-1:0] EXTRA_INIT = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   remap_req,
  output logic [NSLOT-1:0][31:0] words,
  output logic                   remap_fire,
  output logic                   remapped
);
  import adec_pkg::*;

  assign remap_fire = remap_req & ~remapped;

  always_ff @(posedge clk) begin
    if (!rst_n)          remapped <= 1'b0;
    else if (remap_fire) remapped <= 1'b1;
  end

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    localparam logic [31:0] RST = (k == ROM_IDX) ? ROM_INIT :
                                  (k == RAM_IDX) ? RAM_INIT :
                                  (k == BRG_IDX) ? BRG_INIT : EXTRA_INIT[k*32 +: 32];
    if (k == ROM_IDX || k == RAM_IDX) begin : g_moving
      logic [31:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= RST;
        else if (remap_fire)
          q <= (k == ROM_IDX) ? rom_after_remap(words[ROM_IDX], words[RAM_IDX])
                              : ram_after_remap(words[ROM_IDX], words[RAM_IDX]);
      end
      assign words[k] = q;
    end else begin : g_fixed
      assign words[k] = RST;
    end
  end
endmodule

// File: rtl/adec_win_match.sv
module adec_win_match #(
  parameter int NSLOT = 32
) (
  input  logic [31:0]            addr,
  input  logic [NSLOT-1:0][31:0] words,
  output logic [NSLOT-1:0]       hits
);
  import adec_pkg::*;
  for (genvar k = 0; k < NSLOT; k++) begin : g_cmp
    assign hits[k] = win_hit(words[k], addr);
  end
endmodule

// File: rtl/adec_prio_pick.sv
module adec_prio_pick #(
  parameter int NSLOT = 32
) (
  input  logic [NSLOT-1:0] hits,
  output logic [NSLOT-1:0] sel
);
  // isolate the lowest set bit: lowest slot index wins
  assign sel = hits & (~hits + {{(NSLOT-1){1'b0}}, 1'b1});
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
  parameter int NSLOT    = 32,
  parameter int ROM_IDX  = 4,
  parameter int RAM_IDX  = 6,
  parameter int BRG_IDX  = 3,
  parameter logic [31:0] ROM_INIT = 32'h0008_0000,
  parameter logic [31:0] RAM_INIT = 32'h1009_0000,
  parameter logic [31:0] BRG_INIT = 32'h9205_0000,
  parameter logic [NSLOT*32-1:0] EXTRA_INIT = '0,
  localparam int IDXW = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             remap_req,
  input  logic [31:0]      addr,
  output logic [NSLOT-1:0] slave_sel,
  output logic             decode_err,
  input  logic [IDXW-1:0]  cfg_rd_idx,
  output logic [31:0]      cfg_rd_data
);
  logic [NSLOT-1:0][31:0] slot_words;
  logic [NSLOT-1:0]       hits;
  logic                   remap_fire;
  logic                   remapped;

  adec_slot_bank #(
    .NSLOT(NSLOT), .ROM_IDX(ROM_IDX), .RAM_IDX(RAM_IDX), .BRG_IDX(BRG_IDX),
    .ROM_INIT(ROM_INIT), .RAM_INIT(RAM_INIT), .BRG_INIT(BRG_INIT),
    .EXTRA_INIT(EXTRA_INIT)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .remap_req(remap_req),
    .words(slot_words), .remap_fire(remap_fire), .remapped(remapped)
  );

  adec_win_match #(.NSLOT(NSLOT)) u_match (
    .addr(addr), .words(slot_words), .hits(hits)
  );

  adec_prio_pick #(.NSLOT(NSLOT)) u_pick (
    .hits(hits), .sel(slave_sel)
  );

  assign decode_err  = ~|hits;
  assign cfg_rd_data = (int'(cfg_rd_idx) < NSLOT) ? slot_words[cfg_rd_idx] : 32'h0;
endmodule

// File: rtl/adec_chk.sv
module adec_chk #(
  parameter int NSLOT = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSLOT-1:0] hits,
  input logic [NSLOT-1:0] slave_sel,
  input logic             decode_err,
  input logic             remap_fire,
  input logic             remapped,
  input logic [31:0]      rom_word,
  input logic [31:0]      ram_word
);
  assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slave_sel));

  assert_lowest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|slave_sel) |-> (((slave_sel - 1'b1) & hits) == '0));

  assert_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    decode_err == (slave_sel == '0));

  assert_ram_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
    remap_fire |=> (ram_word[31:20] == $past(rom_word[31:20])) &&
                   (ram_word[19:16] == $past(ram_word[19:16])));

  assert_rom_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
    remap_fire |=> (rom_word[31:20] == $past(rom_word[31:20]) + (12'd1 << $past(ram_word[19:16]))) &&
                   (rom_word[19:16] == $past(rom_word[19:16])));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    remapped |=> remapped && $stable(rom_word) && $stable(ram_word));
endmodule

bind addr_window_decoder adec_chk #(.NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .hits(hits), .slave_sel(slave_sel),
  .decode_err(decode_err), .remap_fire(remap_fire), .remapped(remapped),
  .rom_word(slot_words[ROM_IDX]), .ram_word(slot_words[RAM_IDX])
);

// File: tb/tb_addr_window_decoder.sv
`timescale 1ns/1ps
module tb_addr_window_decoder;
  localparam int NS = 32;
  localparam logic [NS*32-1:0] PRI_INIT =
    ((NS*32)'(32'h1001_0000) << (2*32)) | ((NS*32)'(32'h1000_0000) << (5*32));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic remap_req = 1'b0;
  logic [31:0] addr = 32'h0;
  logic [4:0]  rd_idx = 5'd0;
  logic [31:0] sel, sel_p, rd_data, rd_p;
  logic err, err_p;

  always #10 clk = ~clk;

  addr_window_decoder dut (
    .clk(clk), .rst_n(rst_n), .remap_req(remap_req), .addr(addr),
    .slave_sel(sel), .decode_err(err), .cfg_rd_idx(rd_idx), .cfg_rd_data(rd_data));

  addr_window_decoder #(.EXTRA_INIT(PRI_INIT)) dut_pri (
    .clk(clk), .rst_n(rst_n), .remap_req(1'b0), .addr(addr),
    .slave_sel(sel_p), .decode_err(err_p), .cfg_rd_idx(rd_idx), .cfg_rd_data(rd_p));

  typedef struct {
    logic [31:0] sel;
    logic        err;
    bit          pri;
    logic [31:0] a;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int n_run = 0;
  int n_fail = 0;

  // monitor: compares 5 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (sb.size() > 0) begin
        exp_t e;
        logic [31:0] s;
        logic r;
        e = sb.pop_front();
        s = e.pri ? sel_p : sel;
        r = e.pri ? err_p : err;
        n_run++;
        if (s !== e.sel || r !== e.err) begin
          n_fail++;
          $display("FAIL %s addr=%h sel=%h err=%b expected sel=%h err=%b",
                   e.tag, e.a, s, r, e.sel, e.err);
        end
      end
    end
  end

  task automatic drive(input logic [31:0] a, input int slot, input bit pri, input string tag);
    exp_t e;
    @(negedge clk);
    addr = a;
    e.sel = (slot < 0) ? 32'h0 : (32'h1 << slot);
    e.err = (slot < 0);
    e.pri = pri;
    e.a   = a;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic read_chk(input int idx, input logic [31:0] exp_w, input string tag);
    @(negedge clk);
    rd_idx = 5'(idx);
    #5;
    n_run++;
    if (rd_data !== exp_w) begin
      n_fail++;
      $display("FAIL %s slot %0d read=%h expected=%h", tag, idx, rd_data, exp_w);
    end
  endtask

  task automatic pulse_remap();
    @(negedge clk);
    remap_req = 1'b1;
    @(negedge clk);
    remap_req = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  bit done = 1'b0;

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset words via the R9 read port
    read_chk(3, 32'h9205_0000, "R1");
    read_chk(4, 32'h0008_0000, "R1");
    read_chk(6, 32'h1009_0000, "R1");
    read_chk(0, 32'h0,         "R1");
    read_chk(31, 32'h0,        "R1");
    // R2/R5: address 0 goes to ROM, not to the zero-word slots
    drive(32'h0000_0000, 4, 0, "R5 zero slots unused");
    drive(32'h0FFF_FFFF, 4, 0, "R2 rom last");
    drive(32'h1000_0000, 6, 0, "R2 ram first");
    drive(32'h2FFF_FFFF, 6, 0, "R2 ram last");
    drive(32'h3000_0000, -1, 0, "R4 miss after ram");
    drive(32'h9200_0000, 3, 0, "R10 bridge first");
    drive(32'h93FF_FFFF, 3, 0, "R10 bridge last");
    drive(32'h9400_0000, -1, 0, "R10 bridge end");
    drive(32'hFFFF_FFFF, -1, 0, "R4 top miss");
    // R3 priority on overlapping windows
    drive(32'h1000_0000, 2, 1, "R3 lowest of 2/5/6");
    drive(32'h101F_FFFF, 2, 1, "R3 lowest of 2/6");
    drive(32'h1020_0000, 6, 1, "R3 only 6");
    // remap
    pulse_remap();
    read_chk(6, 32'h0009_0000, "R6");
    read_chk(4, 32'h2008_0000, "R7");
    read_chk(3, 32'h9205_0000, "R9 other slot untouched");
    drive(32'h0000_0000, 6, 0, "R6 ram at old rom base");
    drive(32'h1FFF_FFFF, 6, 0, "R6 ram last");
    drive(32'h2000_0000, 4, 0, "R7 rom above ram");
    drive(32'h2FFF_FFFF, 4, 0, "R7 rom last");
    drive(32'h3000_0000, -1, 0, "R4 miss after remap");
    // R8 second request ignored
    pulse_remap();
    read_chk(6, 32'h0009_0000, "R8 ram unchanged");
    read_chk(4, 32'h2008_0000, "R8 rom unchanged");
    drive(32'h2000_0000, 4, 0, "R8 decode unchanged");
    // R8 reset restores
    do_reset();
    read_chk(4, 32'h0008_0000, "R8 reset rom");
    read_chk(6, 32'h1009_0000, "R8 reset ram");
    drive(32'h0000_0000, 4, 0, "R8 reset decode");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule